// File: doc/BRIEF.md
# Asynchronous Host Memory Access Port

This block gives an external host direct read and write access to a processor's internal program memory (24-bit words) and data memory (16-bit words) over a shared 16-bit address/data bus. The host's strobes are asynchronous to the processor clock. The processor keeps running during these accesses and only gives up one memory cycle for each word.

The host first loads a start location. It drives a 14-bit address and a memory-kind bit on the bus and pulses the address-latch strobe low. After that it runs any number of reads or writes. Each access is made by pulling select low together with the read or the write strobe. Every strobe is brought into the clock domain through a two-flop synchronizer and is edge-detected, so one host pulse gives exactly one internal operation. The latched address then steps forward by itself, so a block transfer needs only its start address.

A program word crosses the bus in two transfers. The acknowledge output drops as soon as the host asserts an access strobe, and rises again once the internal operation has been done. Writes into the data-memory window that holds the memory-mapped control registers are dropped.

Top module: `hostmem_port`

## Requirements
- R1: After reset, ack is 1, mem_req is 0, hbus_rd is 0, and the current location is data-memory address 0.
- R2: When al_n goes low, hbus_in[13:0] becomes the current address and hbus_in[14] becomes the memory kind (1 = program memory, 0 = data memory). The load takes effect on the third rising clock edge after the fall. A latch pulse made while an access strobe is asserted is ignored.
- R3: Pulling sel_n low with rd_n or wr_n low starts exactly one access. If that access needs memory, mem_req is 1 for exactly one clock: the cycle after the second rising edge following the strobe assertion. The memory operation completes on the third edge.
- R4: A data-memory write drives mem_we=1, mem_pm=0, mem_addr equal to the current address, and mem_wdata = {8'h00, hbus_in}. The address then increments by one.
- R5: A data-memory read drives mem_we=0. After the third edge, hbus_rd holds mem_rdata[15:0]. The address then increments by one.
- R6: A program-memory write takes two transfers. The first stores hbus_in and makes no memory request. The second issues a write of {first value, hbus_in[7:0]}. The address increments only after the second transfer.
- R7: A program-memory read takes two transfers. The first reads memory and returns bits 23:8 on hbus_rd. The second makes no memory request and returns {8'h00, bits 7:0}. The address increments only after the second transfer.
- R8: The address wraps from 14'h3FFF to 14'h0000.
- R9: A data-memory write at an address at or above CTRL_BASE (default 14'h3FE0) makes no memory request, but the address still increments. Reads there proceed normally.
- R10: ack goes to 0 in the same instant an access strobe is asserted. It stays 0 until the access has completed, then returns to 1.
- R11: Loading a new address resets the program-word transfer phase, so the next transfer counts as the first half of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hbus_in | input | 16 | Host bus value: address/kind in the latch phase, write data in an access |
| hbus_rd | output | 16 | Read data returned to the host |
| al_n | input | 1 | Address-latch strobe, active low, asynchronous |
| sel_n | input | 1 | Port select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ack | output | 1 | Acknowledge, high when the port can take a new strobe |
| mem_req | output | 1 | One-cycle memory operation request |
| mem_we | output | 1 | Memory operation is a write |
| mem_pm | output | 1 | Memory operation targets program memory |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, valid in the request cycle |

## Verification
The bench builds the port with its default parameters: a 14-bit address, a 16-bit bus, 24-bit program words, two synchronizer stages, and the control window starting at 14'h3FE0. With these values, full two-transfer program-word sweeps in both directions are within reach, along with both address wrap corners and the exact boundary of the control-register window. The memory model answers reads with a value computed from the address, so every read result is predicted by arithmetic. Every access also checks the cycle in which the request appears and the acknowledge timing.

// File: rtl/hostmem_pkg.sv
package hostmem_pkg;
  // Index of each host strobe inside the synchronized strobe vector
  localparam int PIN_WR  = 0;
  localparam int PIN_RD  = 1;
  localparam int PIN_SEL = 2;
  localparam int PIN_AL  = 3;
  localparam int PIN_CNT = 4;

  typedef enum logic {KIND_DM = 1'b0, KIND_PM = 1'b1} mem_kind_e;
endpackage

// File: rtl/hostmem_sync.sv
module hostmem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic asserted
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], ~pin_n};
  end

  assign asserted = shift_q[STAGES-1];
endmodule

// File: rtl/hostmem_addr.sv
module hostmem_addr #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_pm,
  input  logic              inc,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_pm
);
  import hostmem_pkg::*;

  mem_kind_e kind_q;
  logic [ADDR_W-1:0] addr_q;

  function automatic logic [ADDR_W-1:0] f_next_addr(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a + 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      kind_q <= KIND_DM;
    end else if (load) begin
      addr_q <= load_addr;
      kind_q <= load_pm ? KIND_PM : KIND_DM;
    end else if (inc) begin
      addr_q <= f_next_addr(addr_q);
    end
  end

  assign cur_addr = addr_q;
  assign cur_pm   = (kind_q == KIND_PM);
endmodule

// File: rtl/hostmem_word.sv
module hostmem_word #(
  parameter int BUS_W = 16,
  parameter int PM_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clr,
  input  logic             is_pm,
  input  logic             is_wr,
  input  logic [BUS_W-1:0] bus_in,
  input  logic [PM_W-1:0]  mem_rdata,
  output logic             phase,
  output logic [BUS_W-1:0] hold_hi,
  output logic [BUS_W-1:0] rd_q
);
  localparam int LOW_W = PM_W - BUS_W;

  logic [LOW_W-1:0] hold_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      hold_hi <= '0;
      hold_lo <= '0;
      rd_q    <= '0;
    end else begin
      if (clr)               phase <= 1'b0;
      else if (start && is_pm) phase <= ~phase;

      if (start) begin
        if (is_wr) begin
          if (is_pm && !phase) hold_hi <= bus_in;
        end else if (is_pm) begin
          if (!phase) begin
            rd_q    <= mem_rdata[PM_W-1:LOW_W];
            hold_lo <= mem_rdata[LOW_W-1:0];
          end else begin
            rd_q <= {{(BUS_W-LOW_W){1'b0}}, hold_lo};
          end
        end else begin
          rd_q <= mem_rdata[BUS_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port #(
  parameter int          ADDR_W      = 14,
  parameter int          BUS_W       = 16,
  parameter int          PM_W        = 24,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CTRL_BASE   = 32'h3FE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  hbus_in,
  output logic [BUS_W-1:0]  hbus_rd,
  input  logic              al_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_pm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PM_W-1:0]   mem_wdata,
  input  logic [PM_W-1:0]   mem_rdata
);
  import hostmem_pkg::*;

  localparam int LOW_W    = PM_W - BUS_W;
  localparam int KIND_BIT = ADDR_W;

  function automatic logic f_is_ctrl(input logic [ADDR_W-1:0] a);
    return 32'(a) >= CTRL_BASE;
  endfunction

  function automatic logic [PM_W-1:0] f_pm_join(input logic [BUS_W-1:0] hi,
                                                 input logic [BUS_W-1:0] lo);
    return {hi, lo[LOW_W-1:0]};
  endfunction

  // Synchronized strobes
  logic [PIN_CNT-1:0] pins_n, lvl;
  assign pins_n[PIN_WR]  = wr_n;
  assign pins_n[PIN_RD]  = rd_n;
  assign pins_n[PIN_SEL] = sel_n;
  assign pins_n[PIN_AL]  = al_n;

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_sync
    hostmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(pins_n[g]), .asserted(lvl[g])
    );
  end

  // Named internal events
  logic act_lvl, act_d, al_d, done_q, raw_act;
  logic access_start, latch_take, addr_inc, need_mem, is_wr, phase;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_pm;
  logic [BUS_W-1:0]  hold_hi;

  assign act_lvl      = lvl[PIN_SEL] & (lvl[PIN_RD] | lvl[PIN_WR]);
  assign raw_act      = ~sel_n & (~rd_n | ~wr_n);
  assign access_start = act_lvl & ~act_d;
  assign is_wr        = lvl[PIN_WR];
  assign ack          = done_q | ~(raw_act | act_lvl);
  assign latch_take   = lvl[PIN_AL] & ~al_d & ack & ~act_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_d  <= 1'b0;
      al_d   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      act_d <= act_lvl;
      al_d  <= lvl[PIN_AL];
      if (!act_lvl)         done_q <= 1'b0;
      else if (access_start) done_q <= 1'b1;
    end
  end

  always_comb begin
    if (cur_pm) need_mem = is_wr ? phase : ~phase;
    else        need_mem = is_wr ? ~f_is_ctrl(cur_addr) : 1'b1;
  end

  assign addr_inc = access_start & (~cur_pm | phase);

  hostmem_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(latch_take), .load_addr(hbus_in[ADDR_W-1:0]), .load_pm(hbus_in[KIND_BIT]),
    .inc(addr_inc), .cur_addr(cur_addr), .cur_pm(cur_pm)
  );

  hostmem_word #(.BUS_W(BUS_W), .PM_W(PM_W)) u_word (
    .clk(clk), .rst_n(rst_n), .start(access_start), .clr(latch_take),
    .is_pm(cur_pm), .is_wr(is_wr), .bus_in(hbus_in), .mem_rdata(mem_rdata),
    .phase(phase), .hold_hi(hold_hi), .rd_q(hbus_rd)
  );

  assign mem_req   = access_start & need_mem;
  assign mem_we    = is_wr;
  assign mem_pm    = cur_pm;
  assign mem_addr  = cur_addr;
  assign mem_wdata = cur_pm ? f_pm_join(hold_hi, hbus_in)
                            : {{(PM_W-BUS_W){1'b0}}, hbus_in};
endmodule

// File: rtl/hostmem_port_chk.sv
module hostmem_port_chk #(
  parameter int          ADDR_W    = 14,
  parameter int unsigned CTRL_BASE = 32'h3FE0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_pm,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              access_start,
  input logic              addr_inc,
  input logic              latch_take,
  input logic              phase
);
  p_single_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_inc && !latch_take) |=> $stable(mem_addr));

  p_ack_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    access_start |-> !ack);

  p_ack_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    access_start |=> ack);

  p_ctrl_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_pm) |-> (32'(mem_addr) < CTRL_BASE));

  p_pm_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (access_start && mem_pm && !latch_take) |=> phase != $past(phase));
endmodule

bind hostmem_port hostmem_port_chk #(.ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .mem_req(mem_req), .mem_we(mem_we),
  .mem_pm(mem_pm), .mem_addr(mem_addr), .access_start(access_start),
  .addr_inc(addr_inc), .latch_take(latch_take), .phase(phase)
);

// File: tb/hostmem_port_tb.sv
`timescale 1ns/1ps
module hostmem_port_tb;
  localparam int CTRL = 'h3FE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hbus_in = '0;
  logic [15:0] hbus_rd;
  logic        al_n = 1'b1, sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        ack, mem_req, mem_we, mem_pm;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [23:0] pat_pm(input logic [13:0] a);
    return {a, 10'h000} ^ 24'hA5C30F;
  endfunction
  function automatic logic [15:0] pat_dm(input logic [13:0] a);
    return {2'b00, a} ^ 16'h5AA5;
  endfunction

  assign mem_rdata = mem_pm ? pat_pm(mem_addr) : {8'hEE, pat_dm(mem_addr)};

  hostmem_port u_dut (
    .clk(clk), .rst_n(rst_n), .hbus_in(hbus_in), .hbus_rd(hbus_rd),
    .al_n(al_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .ack(ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_pm(mem_pm), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic        cap_req, cap_we, cap_pm;
  logic [13:0] cap_addr;
  logic [23:0] cap_wdata;
  logic [15:0] cap_rd;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_latch(input logic [13:0] a, input bit pm);
    @(negedge clk);
    hbus_in = {1'b0, pm, a};
    al_n = 1'b0;
    repeat (4) @(negedge clk);
    al_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_access(input bit wr, input logic [15:0] data,
                           input bit poke, input logic [15:0] poke_val);
    @(negedge clk);
    hbus_in = data;
    sel_n = 1'b0;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    #1 check(ack == 1'b0, "R10", "ack at strobe", ack, 0);
    @(negedge clk);
    check(mem_req == 1'b0, "R3", "early request", mem_req, 0);
    @(negedge clk);
    cap_req = mem_req; cap_we = mem_we; cap_pm = mem_pm;
    cap_addr = mem_addr; cap_wdata = mem_wdata;
    @(negedge clk);
    check(mem_req == 1'b0, "R3", "request width", mem_req, 0);
    check(ack == 1'b1, "R10", "ack after completion", ack, 1);
    cap_rd = hbus_rd;
    if (poke) begin
      hbus_in = poke_val;
      al_n = 1'b0;
      repeat (4) @(negedge clk);
      al_n = 1'b1;
      repeat (3) @(negedge clk);
    end
    sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_req(input string req, input bit we, input bit pm,
                            input logic [13:0] a);
    check(cap_req == 1'b1, req, "request issued", cap_req, 1);
    check(cap_we == we, req, "write flag", cap_we, we);
    check(cap_pm == pm, req, "memory kind", cap_pm, pm);
    check(cap_addr == a, req, "address", cap_addr, a);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ack == 1'b1, "R1", "ack", ack, 1);
    check(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
    check(hbus_rd == 16'h0, "R1", "hbus_rd", hbus_rd, 0);
    do_access(1'b0, 16'h0, 1'b0, 16'h0);
    expect_req("R1", 1'b0, 1'b0, 14'h0);

    // R4 data-memory write sweep
    do_latch(14'd16, 1'b0);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d;
      d = 16'h1000 + 16'(i * 3);
      do_access(1'b1, d, 1'b0, 16'h0);
      expect_req("R4", 1'b1, 1'b0, 14'(16 + i));
      check(cap_wdata == {8'h00, d}, "R4", "write data", cap_wdata, {8'h00, d});
    end

    // R5 data-memory read sweep
    do_latch(14'd16, 1'b0);
    for (int i = 0; i < 16; i++) begin
      do_access(1'b0, 16'h0, 1'b0, 16'h0);
      expect_req("R5", 1'b0, 1'b0, 14'(16 + i));
      check(cap_rd == pat_dm(14'(16 + i)), "R5", "read data", cap_rd, pat_dm(14'(16 + i)));
    end

    // R6 program-memory writes in two halves
    do_latch(14'd40, 1'b1);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] hi;
      hi = 16'hB000 + 16'(i);
      do_access(1'b1, hi, 1'b0, 16'h0);
      check(cap_req == 1'b0, "R6", "no request on first half", cap_req, 0);
      do_access(1'b1, 16'hFF00 | 16'(i), 1'b0, 16'h0);
      expect_req("R6", 1'b1, 1'b1, 14'(40 + i));
      check(cap_wdata == {hi, 8'(i)}, "R6", "joined word", cap_wdata, {hi, 8'(i)});
    end

    // R7 program-memory reads in two halves
    do_latch(14'd40, 1'b1);
    for (int i = 0; i < 8; i++) begin
      logic [23:0] w;
      w = pat_pm(14'(40 + i));
      do_access(1'b0, 16'h0, 1'b0, 16'h0);
      expect_req("R7", 1'b0, 1'b1, 14'(40 + i));
      check(cap_rd == w[23:8], "R7", "upper half", cap_rd, w[23:8]);
      do_access(1'b0, 16'h0, 1'b0, 16'h0);
      check(cap_req == 1'b0, "R7", "no request on second half", cap_req, 0);
      check(cap_rd == {8'h00, w[7:0]}, "R7", "lower half", cap_rd, {8'h00, w[7:0]});
    end

    // R8 wrap, program memory and data memory
    do_latch(14'h3FFF, 1'b1);
    do_access(1'b1, 16'h1234, 1'b0, 16'h0);
    do_access(1'b1, 16'h0056, 1'b0, 16'h0);
    expect_req("R8", 1'b1, 1'b1, 14'h3FFF);
    do_access(1'b1, 16'h789A, 1'b0, 16'h0);
    do_access(1'b1, 16'h00BC, 1'b0, 16'h0);
    expect_req("R8", 1'b1, 1'b1, 14'h0000);
    do_latch(14'h3FFF, 1'b0);
    do_access(1'b0, 16'h0, 1'b0, 16'h0);
    expect_req("R8", 1'b0, 1'b0, 14'h3FFF);
    do_access(1'b0, 16'h0, 1'b0, 16'h0);
    expect_req("R8", 1'b0, 1'b0, 14'h0000);

    // R9 control-register window boundary
    do_latch(14'(CTRL - 1), 1'b0);
    do_access(1'b1, 16'hAAAA, 1'b0, 16'h0);
    expect_req("R9", 1'b1, 1'b0, 14'(CTRL - 1));
    do_access(1'b1, 16'h5555, 1'b0, 16'h0);
    check(cap_req == 1'b0, "R9", "write in control window", cap_req, 0);
    do_access(1'b0, 16'h0, 1'b0, 16'h0);
    expect_req("R9", 1'b0, 1'b0, 14'(CTRL + 1));
    check(cap_rd == pat_dm(14'(CTRL + 1)), "R9", "read in window", cap_rd, pat_dm(14'(CTRL + 1)));

    // R11 new latch restarts the word phase
    do_latch(14'd100, 1'b1);
    do_access(1'b1, 16'h1111, 1'b0, 16'h0);
    do_latch(14'd200, 1'b1);
    do_access(1'b1, 16'h2222, 1'b0, 16'h0);
    check(cap_req == 1'b0, "R11", "first half after relatch", cap_req, 0);
    do_access(1'b1, 16'h0033, 1'b0, 16'h0);
    expect_req("R11", 1'b1, 1'b1, 14'd200);
    check(cap_wdata == 24'h222233, "R11", "joined word", cap_wdata, 24'h222233);

    // R2 latch during an access is ignored
    do_latch(14'd300, 1'b0);
    do_access(1'b0, 16'h0, 1'b1, 16'h01F4);
    expect_req("R2", 1'b0, 1'b0, 14'd300);
    do_access(1'b0, 16'h0, 1'b0, 16'h0);
    expect_req("R2", 1'b0, 1'b0, 14'd301);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule